// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block generates the address for one memory port. It serves one memory, so a chip with separate program and data memories uses one instance for each. Reads and writes both take their address from it. It holds several independent pointer sets. Each set has a current index, a buffer base, a buffer length and a signed step. Typical uses are one buffer per biquad stage of a cascaded IIR filter, or separate buffers for samples and coefficients.

On each access strobe the selected set's index advances by its step. The new index is folded back into the window `[base, base+length)` by the hardware, so the program spends no instructions on buffer bookkeeping. A second mode serves FFT reordering. In that mode a per-set counter advances on each strobe, and the address is the base plus the counter's low N bits in reversed order. N is chosen by an input.

A configuration write port loads the four fields of any set. The address output is combinational from the stored state and the current selects. It is therefore valid in the same cycle as the strobe, and any update takes effect at the clock edge that ends that cycle.

Top module: `circbuf_agen`

## Requirements
- R1: While `rst_n` is low, and just after it rises, every index, base, length, step and reversal counter is zero and `addr_out` is 0.
- R2: When `brev_mode` is 0, `addr_out` equals the index of the set named by `acc_set`. A clock edge with `acc_en` high adds that set's step, read as a two's-complement signed value, to its index.
- R3: When the length is nonzero, a post-modified index at or above base+length has the length subtracted, and one below base has the length added. This keeps the index inside `[base, base+length)` when the index starts inside that window and |step| is at most the length.
- R4: When the length is zero, the post-modify is a plain addition modulo 2^ADDR_W, with no wrap.
- R5: An access changes only the selected set. The other sets keep their index and counter.
- R6: A configuration write picks its field with `cfg_field`: 0 = index, 1 = base, 2 = length, 3 = step. Writing the base sets the index to the new base. Writing the length sets the index to the current base. Both of these writes also clear that set's reversal counter.
- R7: When `brev_mode` is 1, `addr_out` equals the set's base plus the low N bits of its reversal counter in reversed bit order (bit 0 swaps with bit N-1), taken modulo 2^ADDR_W. A strobe then increments the counter and leaves the index unchanged.
- R8: The reversal width N is taken from `brev_bits`. A value of 0 is used as 1, and any value above 10 is used as 10.
- R9: A configuration write and an access to the same set in the same cycle: the write takes effect and the access is dropped.
- R10: When there is neither a strobe nor a configuration write, no set's state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_set | input | 2 | Pointer set to be written |
| cfg_field | input | 2 | Field code: 0 index, 1 base, 2 length, 3 step |
| cfg_data | input | 16 | Value written to the field |
| acc_en | input | 1 | Access strobe; post-modifies at the clock edge |
| acc_set | input | 2 | Pointer set used for the access |
| brev_mode | input | 1 | 1 selects bit-reversed addressing |
| brev_bits | input | 4 | Reversal width N (clamped to 1..10) |
| addr_out | output | 16 | Address of the current access |

## Verification
`addr_out` is combinational, so the address of an access is due in the same cycle as the strobe and is sampled 1 ns after the falling edge on which the inputs were driven. A post-modify or configuration write is due only after the next rising edge. Each step of the bench therefore checks the address of the pending access first, then lets one rising edge pass, and only then looks for the updated state, by peeking through `addr_out` with the strobe low. Checks that a write wins a same-set collision, and that idle cycles leave state untouched, are made through this same peek one edge after the stimulus.

// File: rtl/agen_pkg.sv
package agen_pkg;
   typedef enum logic [1:0] {
      FLD_INDEX  = 2'd0,
      FLD_BASE   = 2'd1,
      FLD_LENGTH = 2'd2,
      FLD_STEP   = 2'd3
   } agen_field_e;
endpackage

// File: rtl/agen_wrap.sv
// Post-modify with circular fold into [base, base+len)
module agen_wrap #(
   parameter int ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] idx,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] len,
   input  logic [ADDR_W-1:0] step,
   output logic [ADDR_W-1:0] nxt
);
   localparam int EXT_W = ADDR_W + 2;

   logic signed [EXT_W-1:0] sum, lo, hi, lenx, fold;

   always_comb begin
      sum  = $signed({2'b00, idx}) + $signed({{2{step[ADDR_W-1]}}, step});
      lo   = $signed({2'b00, base});
      lenx = $signed({2'b00, len});
      hi   = lo + lenx;
      if (len == '0)
         fold = sum;
      else if (sum >= hi)
         fold = sum - lenx;
      else if (sum < lo)
         fold = sum + lenx;
      else
         fold = sum;
      nxt = fold[ADDR_W-1:0];
   end
endmodule

// File: rtl/agen_bitrev.sv
// Reverse the low N bits of a counter, N clamped to 1..MAX_BITS
module agen_bitrev #(
   parameter int MAX_BITS = 10,
   localparam int NB_W = $clog2(MAX_BITS + 1)
) (
   input  logic [MAX_BITS-1:0] cnt,
   input  logic [NB_W-1:0]     nbits,
   output logic [MAX_BITS-1:0] rev
);
   int n_eff;

   always_comb begin
      if (nbits == '0)
         n_eff = 1;
      else if (int'(nbits) > MAX_BITS)
         n_eff = MAX_BITS;
      else
         n_eff = int'(nbits);
      rev = '0;
      for (int i = 0; i < MAX_BITS; i++) begin
         if (i < n_eff)
            rev[i] = cnt[n_eff - 1 - i];
      end
   end
endmodule

// File: rtl/agen_ptr_set.sv
// One pointer set: index, base, length, step and reversal counter
module agen_ptr_set
   import agen_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int MAX_BITS = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  agen_field_e         wr_field,
   input  logic [ADDR_W-1:0]   wr_data,
   input  logic                step_en,
   input  logic                brev,
   output logic [ADDR_W-1:0]   idx_q,
   output logic [ADDR_W-1:0]   base_q,
   output logic [ADDR_W-1:0]   len_q,
   output logic [ADDR_W-1:0]   step_q,
   output logic [MAX_BITS-1:0] cnt_q
);
   logic [ADDR_W-1:0] idx_nxt;

   agen_wrap #(.ADDR_W(ADDR_W)) u_wrap (
      .idx  (idx_q),
      .base (base_q),
      .len  (len_q),
      .step (step_q),
      .nxt  (idx_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q  <= '0;
         base_q <= '0;
         len_q  <= '0;
         step_q <= '0;
         cnt_q  <= '0;
      end else if (wr_en) begin
         unique case (wr_field)
            FLD_INDEX:  idx_q <= wr_data;
            FLD_BASE: begin
               base_q <= wr_data;
               idx_q  <= wr_data;
               cnt_q  <= '0;
            end
            FLD_LENGTH: begin
               len_q <= wr_data;
               idx_q <= base_q;
               cnt_q <= '0;
            end
            FLD_STEP:   step_q <= wr_data;
            default:    ;
         endcase
      end else if (step_en) begin
         if (brev)
            cnt_q <= cnt_q + 1'b1;
         else
            idx_q <= idx_nxt;
      end
   end
endmodule

// File: rtl/circbuf_agen.sv
module circbuf_agen
   import agen_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int NUM_SETS = 4,
   parameter int MAX_BITS = 10,
   localparam int SEL_W   = $clog2(NUM_SETS),
   localparam int NB_W    = $clog2(MAX_BITS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [SEL_W-1:0]  cfg_set,
   input  logic [1:0]        cfg_field,
   input  logic [ADDR_W-1:0] cfg_data,
   input  logic              acc_en,
   input  logic [SEL_W-1:0]  acc_set,
   input  logic              brev_mode,
   input  logic [NB_W-1:0]   brev_bits,
   output logic [ADDR_W-1:0] addr_out
);
   if (NUM_SETS < 2 || (1 << SEL_W) != NUM_SETS) begin : g_chk_sets
      $error("NUM_SETS must be a power of two, at least 2");
   end
   if (MAX_BITS < 1 || MAX_BITS >= ADDR_W) begin : g_chk_bits
      $error("MAX_BITS must lie in 1..ADDR_W-1");
   end

   logic [NUM_SETS-1:0][ADDR_W-1:0]   idx_vec, base_vec, len_vec, step_vec;
   logic [NUM_SETS-1:0][MAX_BITS-1:0] cnt_vec;
   logic [MAX_BITS-1:0]               rev;

   for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
      agen_ptr_set #(.ADDR_W(ADDR_W), .MAX_BITS(MAX_BITS)) u_set (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (cfg_we && cfg_set == SEL_W'(s)),
         .wr_field (agen_field_e'(cfg_field)),
         .wr_data  (cfg_data),
         .step_en  (acc_en && acc_set == SEL_W'(s)),
         .brev     (brev_mode),
         .idx_q    (idx_vec[s]),
         .base_q   (base_vec[s]),
         .len_q    (len_vec[s]),
         .step_q   (step_vec[s]),
         .cnt_q    (cnt_vec[s])
      );
   end

   agen_bitrev #(.MAX_BITS(MAX_BITS)) u_rev (
      .cnt   (cnt_vec[acc_set]),
      .nbits (brev_bits),
      .rev   (rev)
   );

   assign addr_out = brev_mode ? base_vec[acc_set] + ADDR_W'(rev)
                               : idx_vec[acc_set];
endmodule

// File: rtl/agen_chk.sv
module agen_chk #(
   parameter int ADDR_W   = 16,
   parameter int NUM_SETS = 4,
   localparam int SEL_W   = $clog2(NUM_SETS)
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            cfg_we,
   input logic [SEL_W-1:0]                cfg_set,
   input logic [1:0]                      cfg_field,
   input logic [ADDR_W-1:0]               cfg_data,
   input logic                            acc_en,
   input logic [SEL_W-1:0]                acc_set,
   input logic                            brev_mode,
   input logic [ADDR_W-1:0]               addr_out,
   input logic [NUM_SETS-1:0][ADDR_W-1:0] idx_vec,
   input logic [NUM_SETS-1:0][ADDR_W-1:0] base_vec,
   input logic [NUM_SETS-1:0][ADDR_W-1:0] len_vec,
   input logic [NUM_SETS-1:0][ADDR_W-1:0] step_vec
);
   function automatic logic in_win(logic [SEL_W-1:0] s);
      logic [ADDR_W:0] lo, hi, v;
      lo = {1'b0, base_vec[s]};
      hi = lo + {1'b0, len_vec[s]};
      v  = {1'b0, idx_vec[s]};
      return (v >= lo) && (v < hi);
   endfunction

   function automatic logic win_ok(logic [SEL_W-1:0] s);
      logic [ADDR_W:0] hi;
      logic [ADDR_W-1:0] mag;
      hi  = {1'b0, base_vec[s]} + {1'b0, len_vec[s]};
      mag = step_vec[s][ADDR_W-1] ? -step_vec[s] : step_vec[s];
      return (len_vec[s] != '0) && !hi[ADDR_W] && (mag <= len_vec[s]) && in_win(s);
   endfunction

   assert_reset_zero_R1: assert property (@(posedge clk)
      !rst_n |-> addr_out == '0);

   assert_stay_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
      acc_en && !brev_mode && !cfg_we && win_ok(acc_set) |=> in_win($past(acc_set)));

   assert_base_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we && cfg_field == 2'd1 |=> idx_vec[$past(cfg_set)] == $past(cfg_data));

   assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we && acc_en && !brev_mode && cfg_set == acc_set && cfg_field == 2'd3
      |=> idx_vec == $past(idx_vec));

   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we && !acc_en |=> $stable(idx_vec) && $stable(base_vec) &&
                             $stable(len_vec) && $stable(step_vec));
endmodule

bind circbuf_agen agen_chk #(.ADDR_W(ADDR_W), .NUM_SETS(NUM_SETS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .cfg_set   (cfg_set),
   .cfg_field (cfg_field),
   .cfg_data  (cfg_data),
   .acc_en    (acc_en),
   .acc_set   (acc_set),
   .brev_mode (brev_mode),
   .addr_out  (addr_out),
   .idx_vec   (idx_vec),
   .base_vec  (base_vec),
   .len_vec   (len_vec),
   .step_vec  (step_vec)
);

// File: tb/sim_circbuf_agen.sv
`timescale 1ns/1ps
module sim_circbuf_agen;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        cfg_we = 0;
   logic [1:0]  cfg_set = 0;
   logic [1:0]  cfg_field = 0;
   logic [15:0] cfg_data = 0;
   logic        acc_en = 0;
   logic [1:0]  acc_set = 0;
   logic        brev_mode = 0;
   logic [3:0]  brev_bits = 0;
   logic [15:0] addr_out;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   circbuf_agen u0 (.*);

   // set, bit-reversed mode, N, expected address
   localparam int NV = 17;
   localparam int VEC [NV][4] = '{
      '{0, 0, 0, 100}, '{1, 0, 0, 200}, '{0, 0, 0, 102}, '{1, 0, 0, 203},
      '{0, 0, 0, 104}, '{1, 0, 0, 202}, '{0, 0, 0, 101}, '{0, 0, 0, 103},
      '{0, 0, 0, 100}, '{2, 0, 0, 40},  '{2, 0, 0, 43},  '{2, 0, 0, 46},
      '{3, 1, 3, 64},  '{3, 1, 3, 68},  '{3, 1, 3, 66},  '{3, 1, 3, 70},
      '{3, 1, 3, 65}
   };

   task automatic check(input int got, input int exp, input string tag);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
      end
   endtask

   task automatic cfg(input int s, input int f, input int d);
      @(negedge clk);
      cfg_we = 1; cfg_set = 2'(s); cfg_field = 2'(f); cfg_data = 16'(d);
      @(posedge clk); #1;
      cfg_we = 0;
   endtask

   task automatic touch(input int s, input int br, input int n, input bit strobe,
                        input int exp, input string tag);
      @(negedge clk);
      acc_set = 2'(s); brev_mode = br[0]; brev_bits = 4'(n); acc_en = strobe;
      #1 check(int'(addr_out), exp, tag);
      @(posedge clk); #1;
      acc_en = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #1 check(int'(addr_out), 0, "R1 in reset");
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      touch(2, 0, 0, 0, 0, "R1 after release");

      cfg(0, 1, 100); cfg(0, 2, 5); cfg(0, 3, 2);
      cfg(1, 1, 200); cfg(1, 2, 4); cfg(1, 3, 16'hFFFF);
      cfg(2, 1, 40);  cfg(2, 3, 3);
      cfg(3, 1, 64);  cfg(3, 2, 8);

      // R2 R3 R5 R4 R7: table walk
      for (int i = 0; i < NV; i++)
         touch(VEC[i][0], VEC[i][1], VEC[i][2], 1, VEC[i][3],
               $sformatf("R2 R3 R4 R5 R7 row %0d", i));

      touch(1, 0, 0, 0, 201, "R5 set1 unaffected by others");
      touch(2, 0, 0, 0, 49,  "R4 set2 no wrap when length 0");
      touch(3, 0, 0, 0, 64,  "R7 index untouched by reversed accesses");

      cfg(3, 1, 64);
      touch(3, 1, 10, 1, 64,  "R6 counter cleared by base write");
      touch(3, 1, 12, 1, 576, "R8 width above 10 used as 10");
      touch(3, 1, 0,  1, 64,  "R8 width 0 used as 1 (even)");
      touch(3, 1, 0,  1, 65,  "R8 width 0 used as 1 (odd)");

      cfg(0, 2, 7);
      touch(0, 0, 0, 0, 100, "R6 length write reloads base");
      cfg(0, 0, 106);
      touch(0, 0, 0, 1, 106, "R6 index write");
      touch(0, 0, 0, 0, 101, "R3 upper wrap with length 7");

      // R9: write of step collides with access to the same set
      @(negedge clk);
      cfg_we = 1; cfg_set = 0; cfg_field = 3; cfg_data = 1;
      acc_en = 1; acc_set = 0; brev_mode = 0;
      #1 check(int'(addr_out), 101, "R9 address during collision");
      @(posedge clk); #1;
      cfg_we = 0; acc_en = 0;
      touch(0, 0, 0, 0, 101, "R9 access dropped on collision");
      touch(0, 0, 0, 1, 101, "R9 new step in use");
      repeat (3) @(posedge clk);
      touch(0, 0, 0, 0, 102, "R10 idle cycles hold index");

      cfg(2, 3, 16'hFFCE);
      touch(2, 0, 0, 1, 49,    "R4 negative step access");
      touch(2, 0, 0, 0, 65535, "R4 modular wrap below zero");

      @(negedge clk); rst_n = 0;
      #1 check(int'(addr_out), 0, "R1 mid-run reset");
      @(posedge clk); #1 rst_n = 1;
      touch(0, 0, 0, 0, 0, "R1 index cleared");
      touch(3, 1, 4, 0, 0, "R1 base and counter cleared");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule